// File: doc/BRIEF.md
# Serial IRQ Software Interrupt Injector

This block lets host software force interrupts onto a serial IRQ frame without involving any peripheral. It keeps two 8-bit injection registers and a single enable bit. Each injection bit controls one interrupt slot. The bits are active-low: writing 0 to a bit asserts that slot, and writing 1 releases it. A bit keeps its value until the host writes it again, because no other logic in the block changes it.

For every slot, the block merges the injected request with the hardware request that other peripherals present on `hw_irq`. The merged result is `slot_active`, which a serial IRQ slot driver samples once per frame. The enable bit is a master switch. While it is 0, the injection registers are invisible to the stream and every slot follows its hardware request. While it is 1, an injected slot is forced active whatever its hardware source says.

Software reaches the block through a small index/data register port. A write strobe stores the data into the register that the index selects. The read data is a combinational view of the register at the current index, so the host can confirm which slots it is injecting.

Top module: `serirq_soft_inject`

## Requirements
- R1: After reset, both injection registers hold 0xFF, the enable bit is 0, and `slot_active` equals `hw_irq`.
- R2: While the enable bit is 0, `slot_active` equals `hw_irq` for every slot, whatever the injection registers hold.
- R3: While the enable bit is 1, every slot whose injection bit is 0 is active, even when its hardware request is low.
- R4: While the enable bit is 1, every slot whose injection bit is 1 follows its own hardware request.
- R5: Index 0xF2 is the low injection register, whose bit k controls slot k for k = 0..7. Index 0xF3 is the high injection register, whose bit k controls slot k+8.
- R6: The enable bit is bit 0 of the register at index 0xF1. A write sampled on a rising clock edge changes the register state, and therefore `slot_active`, right after that same edge. With no write strobe, the state does not change.
- R7: Reading index 0xF2 or 0xF3 returns the last value written there. Reading 0xF1 returns the enable bit in bit 0 and zeros in bits 7..1. Reading any other index returns 0x00.
- R8: Writes to indices other than 0xF1, 0xF2 and 0xF3 change neither the registers nor `slot_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx | input | 8 | Register index for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_rdata | output | 8 | Read data for `reg_idx` (combinational) |
| hw_irq | input | 16 | Hardware interrupt requests, one bit per slot |
| slot_active | output | 16 | Merged per-slot interrupt state for the slot driver |

## Verification
The checker tests several properties on every cycle:
- the reset values of the registers;
- that `slot_active` can differ from `hw_irq` only in slots that are both enabled and injected;
- that enabled injected slots are always active;
- that register state stays unchanged when there is no write strobe;
- that a write lands on the next edge.

Some behaviours can only be shown by the bench's scenarios. These include the exact slot mapping of each register bit, the read values at mapped and unmapped indices, and the fact that stray writes have no effect. The bench covers them by reading registers back and comparing `slot_active` with a model built from the written values.

// File: rtl/serirq_soft_inject.sv
module serirq_soft_inject #(
  parameter int IDX_W = 8,
  parameter int DATA_W = 8,
  parameter int SLOTS = 16,
  parameter logic [IDX_W-1:0] CFG_IDX = 8'hF1,
  parameter logic [IDX_W-1:0] INJ_BASE_IDX = 8'hF2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_wr,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [SLOTS-1:0]  hw_irq,
  output logic [SLOTS-1:0]  slot_active
);
  localparam int BANKS = SLOTS / DATA_W;

  logic [BANKS-1:0][DATA_W-1:0] inj;
  logic                         inj_en;
  logic [BANKS-1:0]             bank_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) inj_en <= 1'b0;
    else if (reg_wr && reg_idx == CFG_IDX) inj_en <= reg_wdata[0];
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_hit[b] = (reg_idx == INJ_BASE_IDX + IDX_W'(b));
    always_ff @(posedge clk) begin
      if (!rst_n) inj[b] <= '1;
      else if (reg_wr && bank_hit[b]) inj[b] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_idx == CFG_IDX) reg_rdata[0] = inj_en;
    for (int b = 0; b < BANKS; b++)
      if (bank_hit[b]) reg_rdata = inj[b];
  end

  assign slot_active = hw_irq | (~inj & {SLOTS{inj_en}});
endmodule

// File: rtl/serirq_soft_inject_chk.sv
module serirq_soft_inject_chk #(
  parameter int IDX_W = 8,
  parameter int DATA_W = 8,
  parameter int SLOTS = 16,
  parameter logic [IDX_W-1:0] CFG_IDX = 8'hF1,
  parameter logic [IDX_W-1:0] INJ_BASE_IDX = 8'hF2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IDX_W-1:0]  reg_idx,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              reg_wr,
  input logic [SLOTS-1:0]  hw_irq,
  input logic [SLOTS-1:0]  slot_active,
  input logic [SLOTS-1:0]  inj_vec,
  input logic              inj_en
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (inj_vec == '1 && !inj_en));

  assert_only_injected_differ_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_active ^ hw_irq) & ~(~inj_vec & {SLOTS{inj_en}})) == '0);

  assert_injected_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inj_en |-> ((~inj_vec & ~slot_active) == '0));

  assert_quiet_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ($stable(inj_vec) && $stable(inj_en)));

  assert_enable_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == CFG_IDX) |=> (inj_en == $past(reg_wdata[0])));

  assert_low_bank_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == INJ_BASE_IDX) |=> (inj_vec[DATA_W-1:0] == $past(reg_wdata)));
endmodule

bind serirq_soft_inject serirq_soft_inject_chk #(
  .IDX_W(IDX_W), .DATA_W(DATA_W), .SLOTS(SLOTS),
  .CFG_IDX(CFG_IDX), .INJ_BASE_IDX(INJ_BASE_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
  .reg_wr(reg_wr), .hw_irq(hw_irq), .slot_active(slot_active),
  .inj_vec(inj), .inj_en(inj_en)
);

// File: tb/test_serirq_soft_inject.sv
module test_serirq_soft_inject;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_idx = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_rdata;
  logic [15:0] hw_irq = '0;
  logic [15:0] slot_active;

  int checks = 0;
  int fails = 0;
  logic [7:0] m_lo = 8'hFF, m_hi = 8'hFF;
  logic       m_en = 1'b0;

  always #2 clk = ~clk;

  serirq_soft_inject i_serirq_soft_inject (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .hw_irq(hw_irq), .slot_active(slot_active)
  );

  function automatic logic [15:0] exp_slots(logic en, logic [7:0] lo, logic [7:0] hi, logic [15:0] hw);
    logic [15:0] r;
    for (int k = 0; k < 16; k++) begin
      if (en && ((k < 8) ? !lo[k] : !hi[k-8])) r[k] = 1'b1;
      else r[k] = hw[k];
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_read(logic [7:0] idx);
    if (idx == 8'hF1) return {7'd0, m_en};
    if (idx == 8'hF2) return m_lo;
    if (idx == 8'hF3) return m_hi;
    return 8'h00;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic wr(logic [7:0] idx, logic [7:0] d);
    @(negedge clk);
    reg_idx = idx; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (idx == 8'hF1) m_en = d[0];
    else if (idx == 8'hF2) m_lo = d;
    else if (idx == 8'hF3) m_hi = d;
  endtask

  task automatic rd_check(string req, logic [7:0] idx);
    reg_idx = idx;
    #1;
    check(req, {8'h00, reg_rdata}, {8'h00, exp_read(idx)});
  endtask

  task automatic slots_check(string req);
    #1;
    check(req, slot_active, exp_slots(m_en, m_lo, m_hi, hw_irq));
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    hw_irq = 16'h1234;
    // R1 reset state
    slots_check("R1");
    rd_check("R1", 8'hF1);
    rd_check("R1", 8'hF2);
    rd_check("R1", 8'hF3);
    // R2 injection ignored while disabled
    wr(8'hF2, 8'h00);
    wr(8'hF3, 8'h00);
    slots_check("R2");
    check("R2", slot_active, hw_irq);
    // R6 enable takes effect right after its edge
    @(negedge clk);
    reg_idx = 8'hF1; reg_wdata = 8'h01; reg_wr = 1'b1;
    #1 check("R6", slot_active, hw_irq);
    @(negedge clk);
    reg_wr = 1'b0; m_en = 1'b1;
    #1 check("R6", slot_active, 16'hFFFF);
    // R5 slot mapping, R3/R4 priority
    hw_irq = 16'h0000;
    wr(8'hF2, 8'hFE);
    wr(8'hF3, 8'hFF);
    check("R5", slot_active, 16'h0001);
    wr(8'hF2, 8'hFF);
    wr(8'hF3, 8'h7F);
    check("R5", slot_active, 16'h8000);
    hw_irq = 16'h0101;
    #1 check("R4", slot_active, 16'h8101);
    wr(8'hF3, 8'hFE);
    check("R3", slot_active, 16'h0101);
    hw_irq = 16'h0000;
    #1 check("R3", slot_active, 16'h0100);
    // R8 stray writes ignored, R7 readback
    wr(8'hF0, 8'h00);
    wr(8'hF4, 8'h00);
    slots_check("R8");
    rd_check("R8", 8'hF2);
    rd_check("R7", 8'hF3);
    rd_check("R7", 8'h10);
    wr(8'hF1, 8'hFE);
    rd_check("R7", 8'hF1);
    slots_check("R2");
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] idx;
      case ($urandom_range(0, 4))
        0: idx = 8'hF1;
        1: idx = 8'hF2;
        2: idx = 8'hF3;
        default: idx = 8'($urandom);
      endcase
      hw_irq = 16'($urandom);
      if ($urandom_range(0, 3) != 0) wr(idx, 8'($urandom));
      else @(negedge clk);
      slots_check(m_en ? "R3" : "R2");
      rd_check("R7", 8'($urandom_range(8'hEF, 8'hF4)));
    end
    // R1 re-reset
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_en = 1'b0; m_lo = 8'hFF; m_hi = 8'hFF;
    slots_check("R1");
    rd_check("R1", 8'hF2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule